// File: doc/BRIEF.md
# Supply-Section Control and Diagnostic Register over I2C

This block is the two-wire serial slave that governs one supply section of a dual set-top supply chip. The host writes one control byte. The byte enables the section and sets the output voltage level, the cable-drop compensation, the continuous tone, the tone-transmit path, the pulsed current limiting, the low-current test threshold and the auxiliary high-voltage test mode. The host reads back one status byte. That byte combines five live fault and monitor flags with copies of the enable, voltage-select and drop-compensation bits as they were last written.

Two slave addresses are available, and a strap pin picks the one the section answers to. The serial lines are synchronised to a local clock and oversampled, so START and STOP are detected from the sampled levels. While the supply is in under-voltage lockout the slave gives no acknowledge, and no register write can take place. The block also turns the control bits and a fast voltage-switch pin into two 3-bit level codes. One code is for the linear output stage and one is for the step-up converter.

Top module: `lnb_ctl_slave`

## Requirements
- R1: After reset all eight control outputs are 0, both voltage codes are 0 (off) and the SDA pull-down is released.
- R2: A write transfer stores the data byte in the control outputs with this bit layout: bit0 enable, bit1 voltage select, bit2 drop compensation, bit3 continuous tone, bit4 tone-transmit path, bit5 pulsed limit, bit6 test threshold, bit7 auxiliary mode. The write needs a START, the 7-bit address followed by R/W=0, an acknowledge and then the data byte.
- R3: The slave answers only address 0x08 when addr_sel_i is 0, and only address 0x09 when addr_sel_i is 1. It does not acknowledge any other address, and such a transfer leaves the control outputs unchanged.
- R4: Bytes are received MSB first. The slave acknowledges each accepted byte by pulling SDA low for the whole ninth clock.
- R5: A read (R/W=1) returns this byte, MSB first: bit7 low-current flag, bit6 voltage monitor, bit5 tone monitor, bit4 over-temperature, bit3 over-load, bit2 drop compensation, bit1 voltage select, bit0 enable. The flags are sampled when the address acknowledge ends.
- R6: The voltage monitor bit reads 0 whenever drop compensation or auxiliary mode is set.
- R7: While uvlo_i is 1 the slave gives no acknowledge, neither to an address nor to a data byte, and the control outputs do not change.
- R8: A transfer cut short by a STOP before a data byte completes leaves the control outputs unchanged.
- R9: Output code values are 0 off, 1 for 13.4 V, 2 for 14.4 V, 3 for 18.5 V, 4 for 19.5 V and 5 for 22 V. With enable at 0 the output code is 0. With auxiliary mode set it is 5. Otherwise voltage select 0 gives 1, or 2 when drop compensation is set.
- R10: With enable set, auxiliary mode clear and voltage select at 1, vfast_i at 0 forces output code 1. vfast_i at 1 gives 3, or 4 when drop compensation is set.
- R11: The step-up code follows R9 and R10 as if vfast_i were 1. It never depends on vfast_i.
- R12: Several data bytes in one write transfer are each acknowledged and each stored. The last one remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_pd_o | output | 1 | 1 pulls the data line low |
| addr_sel_i | input | 1 | Address strap select |
| uvlo_i | input | 1 | Supply under-voltage lockout active |
| vfast_i | input | 1 | Fast voltage switch, 0 forces the low level |
| diag_imon_i | input | 1 | Low-current flag |
| diag_vmon_i | input | 1 | Output-voltage monitor flag |
| diag_tmon_i | input | 1 | Tone monitor flag |
| diag_otf_i | input | 1 | Over-temperature flag |
| diag_olf_i | input | 1 | Over-load flag |
| ctrl_en_o | output | 1 | Section enable |
| ctrl_vsel_o | output | 1 | Voltage select |
| ctrl_llc_o | output | 1 | Drop compensation |
| ctrl_ten_o | output | 1 | Continuous tone |
| ctrl_ttx_o | output | 1 | Tone-transmit path |
| ctrl_pcl_o | output | 1 | Pulsed current limiting |
| ctrl_itest_o | output | 1 | Low-current test threshold |
| ctrl_aux_o | output | 1 | Auxiliary high-voltage mode |
| vout_code_o | output | 3 | Linear stage level code |
| vup_code_o | output | 3 | Step-up level code |

## Verification
Two things can fall on the same falling SCL edge. The first is the decision to open an acknowledge. The second is a change on the under-voltage input, which must block that acknowledge. The bench provokes this by raising uvlo_i after the address has been acknowledged but before the data byte ends. It then requires a NACK on the data byte and unchanged control outputs. A second overlap arises because a stored byte and the voltage-code remap take effect together. Each write in the sweep is therefore followed by a check of both codes against the just-written bits, for both vfast_i levels.

// File: rtl/lnb_ctl_pkg.sv
package lnb_ctl_pkg;

  typedef enum logic [2:0] {
    VC_OFF = 3'd0,
    VC_13  = 3'd1,
    VC_14  = 3'd2,
    VC_18  = 3'd3,
    VC_19  = 3'd4,
    VC_22  = 3'd5
  } vcode_e;

  // bit7 .. bit0 of the write byte
  typedef struct packed {
    logic aux;
    logic itest;
    logic pcl;
    logic ttx;
    logic ten;
    logic llc;
    logic vsel;
    logic en;
  } ctrl_t;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_WDAT, S_WACK, S_RDAT, S_RACK
  } slv_st_e;

  function automatic vcode_e vup_map(input ctrl_t c);
    if (!c.en)  return VC_OFF;
    if (c.aux)  return VC_22;
    if (c.vsel) return c.llc ? VC_19 : VC_18;
    return c.llc ? VC_14 : VC_13;
  endfunction

  function automatic vcode_e vout_map(input ctrl_t c, input logic fast);
    if (c.en && !c.aux && c.vsel && !fast) return VC_13;
    return vup_map(c);
  endfunction

  function automatic logic [7:0] read_pack(input ctrl_t c, input logic imon,
                                           input logic vmon, input logic tmon,
                                           input logic otf, input logic olf);
    logic vmon_ok;
    vmon_ok = vmon & ~c.llc & ~c.aux;
    return {imon, vmon_ok, tmon, otf, olf, c.llc, c.vsel, c.en};
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  localparam int DEPTH = SYNC_STAGES + 1;

  logic [DEPTH-1:0] scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[DEPTH-2:0], scl_i};
      sda_p <= {sda_p[DEPTH-2:0], sda_i};
    end
  end

  logic scl_now, scl_old, sda_old;
  assign scl_now = scl_p[DEPTH-2];
  assign scl_old = scl_p[DEPTH-1];
  assign sda_s   = sda_p[DEPTH-2];
  assign sda_old = sda_p[DEPTH-1];

  assign scl_rise  =  scl_now & ~scl_old;
  assign scl_fall  = ~scl_now &  scl_old;
  assign start_evt =  scl_now &  scl_old &  sda_old & ~sda_s;
  assign stop_evt  =  scl_now &  scl_old & ~sda_old &  sda_s;
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import lnb_ctl_pkg::*;
#(
  parameter logic [6:0] ADDR_LO = 7'h08,
  parameter logic [6:0] ADDR_HI = 7'h09,
  parameter int         BYTE_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              addr_sel,
  input  logic              uvlo,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic [BYTE_W-1:0] wr_byte,
  output logic              wr_commit,
  output logic              in_ack,
  output logic              sda_pd
);
  localparam int CW = $clog2(BYTE_W + 1);
  localparam logic [CW-1:0] FULL = CW'(BYTE_W);

  slv_st_e           st;
  logic [CW-1:0]     bit_cnt;
  logic [BYTE_W-1:0] rx_sr, tx_sr;
  logic              rw, mack;
  logic [6:0]        my_addr;
  logic              addr_hit;

  assign my_addr  = addr_sel ? ADDR_HI : ADDR_LO;
  assign addr_hit = (rx_sr[BYTE_W-1 -: 7] == my_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      bit_cnt <= '0;
      rx_sr   <= '0;
      tx_sr   <= '0;
      rw      <= 1'b0;
      mack    <= 1'b0;
      sda_pd  <= 1'b0;
    end else if (start_evt) begin
      st      <= S_ADDR;
      bit_cnt <= '0;
      sda_pd  <= 1'b0;
    end else if (stop_evt) begin
      st      <= S_IDLE;
      sda_pd  <= 1'b0;
    end else begin
      unique case (st)
        S_ADDR, S_WDAT: begin
          if (scl_rise && bit_cnt < FULL) begin
            rx_sr   <= {rx_sr[BYTE_W-2:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (scl_fall && bit_cnt == FULL) begin
            if (st == S_ADDR) begin
              if (addr_hit && !uvlo) begin
                st     <= S_AACK;
                sda_pd <= 1'b1;
                rw     <= rx_sr[0];
              end else begin
                st <= S_IDLE;
              end
            end else if (!uvlo) begin
              st     <= S_WACK;
              sda_pd <= 1'b1;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        S_AACK: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            if (rw) begin
              st     <= S_RDAT;
              sda_pd <= ~rd_byte[BYTE_W-1];
              tx_sr  <= {rd_byte[BYTE_W-2:0], 1'b0};
            end else begin
              st     <= S_WDAT;
              sda_pd <= 1'b0;
            end
          end
        end
        S_WACK: begin
          if (scl_fall) begin
            st      <= S_WDAT;
            bit_cnt <= '0;
            sda_pd  <= 1'b0;
          end
        end
        S_RDAT: begin
          if (scl_rise) begin
            bit_cnt <= bit_cnt + 1'b1;
          end else if (scl_fall) begin
            if (bit_cnt == FULL) begin
              st     <= S_RACK;
              sda_pd <= 1'b0;
            end else begin
              sda_pd <= ~tx_sr[BYTE_W-1];
              tx_sr  <= {tx_sr[BYTE_W-2:0], 1'b0};
            end
          end
        end
        S_RACK: begin
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            if (mack) begin
              st      <= S_RDAT;
              bit_cnt <= '0;
              sda_pd  <= ~rd_byte[BYTE_W-1];
              tx_sr   <= {rd_byte[BYTE_W-2:0], 1'b0};
            end else begin
              st <= S_IDLE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign wr_byte   = rx_sr;
  assign wr_commit = (st == S_WACK) && scl_fall && !start_evt && !stop_evt;
  assign in_ack    = (st == S_AACK) || (st == S_WACK);
endmodule

// File: rtl/ctrl_reg_bank.sv
module ctrl_reg_bank #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q[i] <= 1'b0;
      else if (load) q[i] <= d[i];
    end
  end
endmodule

// File: rtl/vcode_map.sv
module vcode_map
  import lnb_ctl_pkg::*;
(
  input  ctrl_t      ctrl,
  input  logic       fast,
  output logic [2:0] vout_code,
  output logic [2:0] vup_code
);
  always_comb begin
    vout_code = vout_map(ctrl, fast);
    vup_code  = vup_map(ctrl);
  end
endmodule

// File: rtl/lnb_ctl_slave.sv
module lnb_ctl_slave
  import lnb_ctl_pkg::*;
#(
  parameter logic [6:0] ADDR_LO     = 7'h08,
  parameter logic [6:0] ADDR_HI     = 7'h09,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pd_o,
  input  logic       addr_sel_i,
  input  logic       uvlo_i,
  input  logic       vfast_i,
  input  logic       diag_imon_i,
  input  logic       diag_vmon_i,
  input  logic       diag_tmon_i,
  input  logic       diag_otf_i,
  input  logic       diag_olf_i,
  output logic       ctrl_en_o,
  output logic       ctrl_vsel_o,
  output logic       ctrl_llc_o,
  output logic       ctrl_ten_o,
  output logic       ctrl_ttx_o,
  output logic       ctrl_pcl_o,
  output logic       ctrl_itest_o,
  output logic       ctrl_aux_o,
  output logic [2:0] vout_code_o,
  output logic [2:0] vup_code_o
);
  localparam int BYTE_W = $bits(ctrl_t);

  // named internal events, used by the bound checker
  logic sda_s_w, scl_rise_w, scl_fall_w, start_w, stop_w;
  logic commit_w, in_ack_w;
  logic [BYTE_W-1:0] wr_byte_w, rd_byte_w, ctrl_q;
  ctrl_t ctrl;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s_w),
    .scl_rise  (scl_rise_w),
    .scl_fall  (scl_fall_w),
    .start_evt (start_w),
    .stop_evt  (stop_w)
  );

  i2c_slave_fsm #(.ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI), .BYTE_W(BYTE_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_s     (sda_s_w),
    .scl_rise  (scl_rise_w),
    .scl_fall  (scl_fall_w),
    .start_evt (start_w),
    .stop_evt  (stop_w),
    .addr_sel  (addr_sel_i),
    .uvlo      (uvlo_i),
    .rd_byte   (rd_byte_w),
    .wr_byte   (wr_byte_w),
    .wr_commit (commit_w),
    .in_ack    (in_ack_w),
    .sda_pd    (sda_pd_o)
  );

  ctrl_reg_bank #(.WIDTH(BYTE_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (commit_w),
    .d     (wr_byte_w),
    .q     (ctrl_q)
  );

  assign ctrl = ctrl_t'(ctrl_q);

  assign rd_byte_w = read_pack(ctrl, diag_imon_i, diag_vmon_i, diag_tmon_i,
                               diag_otf_i, diag_olf_i);

  vcode_map u_vmap (
    .ctrl      (ctrl),
    .fast      (vfast_i),
    .vout_code (vout_code_o),
    .vup_code  (vup_code_o)
  );

  assign ctrl_en_o    = ctrl.en;
  assign ctrl_vsel_o  = ctrl.vsel;
  assign ctrl_llc_o   = ctrl.llc;
  assign ctrl_ten_o   = ctrl.ten;
  assign ctrl_ttx_o   = ctrl.ttx;
  assign ctrl_pcl_o   = ctrl.pcl;
  assign ctrl_itest_o = ctrl.itest;
  assign ctrl_aux_o   = ctrl.aux;
endmodule

// File: rtl/lnb_ctl_slave_chk.sv
module lnb_ctl_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       uvlo_i,
  input logic       vfast_i,
  input logic       sda_pd_o,
  input logic [7:0] ctrl_q,
  input logic [2:0] vout_code_o,
  input logic [2:0] vup_code_o,
  input logic       scl_fall_w,
  input logic       start_w,
  input logic       stop_w,
  input logic       in_ack_w,
  input logic       commit_w
);
  // R7
  uvlo_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ack_w) |-> $past(!uvlo_i));

  // R4
  pd_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pd_o != $past(sda_pd_o)) |-> $past(scl_fall_w || start_w || stop_w));

  // R2
  reg_only_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q != $past(ctrl_q)) |-> $past(commit_w));

  // R9
  standby_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[0] |-> (vout_code_o == 3'd0 && vup_code_o == 3'd0));

  // R9
  aux_forces_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[0] && ctrl_q[7]) |-> (vout_code_o == 3'd5 && vup_code_o == 3'd5));

  // R10
  fast_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[0] && !ctrl_q[7] && ctrl_q[1] && !vfast_i) |-> vout_code_o == 3'd1);

  // R11
  vup_not_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vup_code_o >= vout_code_o);
endmodule

bind lnb_ctl_slave lnb_ctl_slave_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .uvlo_i      (uvlo_i),
  .vfast_i     (vfast_i),
  .sda_pd_o    (sda_pd_o),
  .ctrl_q      (ctrl_q),
  .vout_code_o (vout_code_o),
  .vup_code_o  (vup_code_o),
  .scl_fall_w  (scl_fall_w),
  .start_w     (start_w),
  .stop_w      (stop_w),
  .in_ack_w    (in_ack_w),
  .commit_w    (commit_w)
);

// File: tb/lnb_ctl_slave_tb_top.sv
module lnb_ctl_slave_tb_top;
  localparam int Q = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic addr_sel = 1'b0, uvlo = 1'b0, vfast = 1'b1;
  logic [4:0] diag = 5'b0; // {imon, vmon, tmon, otf, olf}
  logic sda_pd;
  logic en, vsel, llc, ten, ttx, pcl, itest, aux;
  logic [2:0] vout, vup;
  wire  sda_bus = sda_m & ~sda_pd;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lnb_ctl_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_pd_o(sda_pd),
    .addr_sel_i(addr_sel), .uvlo_i(uvlo), .vfast_i(vfast),
    .diag_imon_i(diag[4]), .diag_vmon_i(diag[3]), .diag_tmon_i(diag[2]),
    .diag_otf_i(diag[1]), .diag_olf_i(diag[0]),
    .ctrl_en_o(en), .ctrl_vsel_o(vsel), .ctrl_llc_o(llc), .ctrl_ten_o(ten),
    .ctrl_ttx_o(ttx), .ctrl_pcl_o(pcl), .ctrl_itest_o(itest), .ctrl_aux_o(aux),
    .vout_code_o(vout), .vup_code_o(vup)
  );

  function automatic logic [7:0] ctrl_now();
    return {aux, itest, pcl, ttx, ten, llc, vsel, en};
  endfunction

  // level table: code = 0 off, 1 13.4, 2 14.4, 3 18.5, 4 19.5, 5 22
  function automatic int exp_level(input logic [7:0] c, input logic fast, input bit stepup);
    int base;
    if (c[0] == 1'b0) return 0;
    if (c[7]) return 5;
    base = c[1] ? 3 : 1;
    if (c[1] && !stepup && !fast) return 1;
    return base + (c[2] ? 1 : 0);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic clk_bit(input logic b, output logic seen);
    sda_m = b; tick(Q);
    scl_m = 1'b1; tick(Q);
    seen = sda_bus; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(d[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      d[i] = s;
    end
    clk_bit(~give_ack, s);
  endtask

  task automatic i2c_write(input logic [6:0] a, input logic [7:0] d,
                           output logic aack, output logic dack);
    i2c_start();
    send_byte({a, 1'b0}, aack);
    dack = 1'b0;
    if (aack) send_byte(d, dack);
    i2c_stop();
  endtask

  task automatic i2c_read(input logic [6:0] a, output logic aack, output logic [7:0] d);
    i2c_start();
    send_byte({a, 1'b1}, aack);
    d = 8'hxx;
    if (aack) recv_byte(1'b0, d);
    i2c_stop();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic a1, a2;
    logic [7:0] rb, c, ex;
    tick(10);
    rst_n = 1'b1;
    tick(5);
    // R1 reset state
    check("R1 ctrl", ctrl_now(), 0);
    check("R1 vout", vout, 0);
    check("R1 vup", vup, 0);
    check("R1 pd", sda_pd, 0);

    // R2 R4 basic write to the low address
    i2c_write(7'h08, 8'hA5, a1, a2);
    check("R4 addr ack", a1, 1);
    check("R4 data ack", a2, 1);
    check("R2 stored", ctrl_now(), 8'hA5);

    // R3 wrong address ignored
    i2c_write(7'h09, 8'h5A, a1, a2);
    check("R3 other addr nack", a1, 0);
    check("R3 unchanged", ctrl_now(), 8'hA5);
    addr_sel = 1'b1;
    i2c_write(7'h08, 8'h11, a1, a2);
    check("R3 low addr nack when sel=1", a1, 0);
    i2c_write(7'h09, 8'h3C, a1, a2);
    check("R3 high addr ack", a1 & a2, 1);
    check("R3 stored", ctrl_now(), 8'h3C);
    addr_sel = 1'b0;

    // R9 R10 R11 sweep of en, vsel, llc, aux with both vfast levels
    for (int k = 0; k < 16; k++) begin
      c = {k[3], 4'b0101, k[2], k[1], k[0]};
      i2c_write(7'h08, c, a1, a2);
      check("R2 sweep store", ctrl_now(), c);
      for (int f = 0; f < 2; f++) begin
        vfast = f[0];
        tick(2);
        check("R9 R10 vout", vout, exp_level(c, vfast, 1'b0));
        check("R11 vup", vup, exp_level(c, vfast, 1'b1));
      end
    end
    vfast = 1'b1;

    // R5 read layout over all flag patterns, llc=aux=0
    i2c_write(7'h08, 8'h03, a1, a2);
    for (int p = 0; p < 32; p++) begin
      diag = p[4:0];
      i2c_read(7'h08, a1, rb);
      ex = {p[4], p[3], p[2], p[1], p[0], 3'b011};
      check("R5 read ack", a1, 1);
      check("R5 read byte", rb, ex);
    end

    // R6 voltage monitor hidden by llc or aux
    diag = 5'b01000;
    i2c_write(7'h08, 8'h07, a1, a2);
    i2c_read(7'h08, a1, rb);
    check("R6 llc hides vmon", rb, 8'h07);
    i2c_write(7'h08, 8'h83, a1, a2);
    i2c_read(7'h08, a1, rb);
    check("R6 aux hides vmon", rb, 8'h03);
    diag = 5'b0;

    // R7 lockout: no address ack, no change
    i2c_write(7'h08, 8'h42, a1, a2);
    uvlo = 1'b1;
    i2c_write(7'h08, 8'h99, a1, a2);
    check("R7 addr nack", a1, 0);
    check("R7 unchanged", ctrl_now(), 8'h42);
    uvlo = 1'b0;
    // R7 lockout arriving between address ack and end of data byte
    i2c_start();
    send_byte({7'h08, 1'b0}, a1);
    uvlo = 1'b1;
    send_byte(8'hE7, a2);
    i2c_stop();
    uvlo = 1'b0;
    check("R7 late addr ack", a1, 1);
    check("R7 late data nack", a2, 0);
    check("R7 late unchanged", ctrl_now(), 8'h42);

    // R8 abort mid data byte
    i2c_start();
    send_byte({7'h08, 1'b0}, a1);
    for (int i = 0; i < 4; i++) clk_bit(1'b1, a2);
    i2c_stop();
    check("R8 abort unchanged", ctrl_now(), 8'h42);

    // R12 two data bytes in one transfer
    i2c_start();
    send_byte({7'h08, 1'b0}, a1);
    send_byte(8'h81, a2);
    check("R12 first ack", a2, 1);
    tick(2);
    check("R12 first stored", ctrl_now(), 8'h81);
    send_byte(8'h26, a2);
    i2c_stop();
    check("R12 second ack", a2, 1);
    check("R12 last stored", ctrl_now(), 8'h26);

    finish_run();
  end
endmodule